// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer

This block holds five down-counting timer channels behind a small word-addressed register bus. Channels 0 to 3 each produce one PWM output; channel 4 is a plain countdown timer whose count can only be seen through the bus. All timing runs from the system clock through a chain of clock enables. Two 8-bit prescalers are shared: one serves channels 0 and 1, and the other serves channels 2, 3 and 4. Each channel then divides its prescaler tick by a power of two that it selects for itself.

Software writes a reload value and a compare value into a channel's buffers. It sets the channel's load bit so that the buffers are copied into the live counter and comparator, and then clears that bit and sets the run bit. While running, the counter steps down once per channel tick. When it reaches zero it either reloads from the buffers or stays at zero, depending on the channel's repeat bit. The output is active while the live count is at or below the compare value, so a larger compare value gives a longer active time. A per-channel invert bit flips the output polarity.

Top module: `pwm_timer`

## Requirements
- R1: After reset every register reads zero, every live count is zero and all four outputs are low.
- R2: Word address map: 0 holds the prescalers (bits [7:0] for channels 0-1, bits [15:8] for channels 2-4); 1 holds the divider selects (4 bits per channel, channel n at bits [4n+3:4n]); 2 is the control word; channel n uses address 3+3n for its reload buffer, 4+3n for its compare buffer and 5+3n for its live count, which is read-only. Channel 4's compare address reads zero and ignores writes. Unused bits and addresses read zero.
- R3: A running channel steps its count once every (P+1)*2^n clocks, where P is its group's prescaler value and n is its divider select.
- R4: While a channel's load bit is set, the live count and compare are copied from the buffers on every clock and no counting takes place, even if a tick falls in the same cycle.
- R5: A running counter decrements by one per tick. On a tick at zero with the repeat bit set, it reloads both the count and the compare from the buffers.
- R6: With the repeat bit clear, a running counter that reaches zero stays at zero.
- R7: While running, output n is high exactly when (live count <= live compare) XOR invert bit.
- R8: With the run bit clear, the live count is frozen and the output equals the invert bit.
- R9: Control word layout: channel 0 uses bits [3:0] and channel n (1-4) uses bits [8+4(n-1)+3 : 8+4(n-1)]; within a group, bit 0 is run, bit 1 is load, bit 2 is invert and bit 3 is repeat. Channel 4 has no invert bit, so bit 22 and bits [7:4] always read zero.
- R10: Channel 4 counts down and reloads like the others, but it drives no output pin and its count is visible only at address 17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Word address |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write enable; the write takes effect at the next rising edge |
| busRdata | output | 32 | Read data, combinational from busAddr |
| pwmOut | output | 4 | PWM outputs of channels 0 to 3 |

## Verification
A load bit can be held while the channel's tick fires, and a counter can reach zero on the same edge as a bus write changes its reload buffer or control bits. The bench holds load and run together across many ticks, and rewrites buffers and control words while counters are mid-period or at zero. A behavioural model is stepped on each edge from the values seen before that edge. Its outputs and bus read value are compared with the design after every edge, which shows whether load beats counting and whether a reload picks up the buffer value that was present before the edge.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int NUM_CH    = 5;
  localparam int NUM_PWM   = 4;
  localparam int NUM_GRP   = 2;
  localparam int CNT_W     = 16;
  localparam int PRE_W     = 8;
  localparam int DIV_W     = 4;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 5;
  localparam int GRP_BITS  = 4;
  localparam int DIVCNT_W  = (1 << DIV_W) - 1;
  localparam int CTRL_W    = 8 + GRP_BITS * (NUM_CH - 1);
  localparam int REG_BASE  = 3;
  localparam int REG_STEP  = 3;

  // Per-channel configuration strobes passed from control to datapath
  typedef struct packed {
    logic             run;
    logic             load;
    logic             invert;
    logic             repeatOn;
    logic [DIV_W-1:0] divSel;
    logic [CNT_W-1:0] cntBuf;
    logic [CNT_W-1:0] cmpBuf;
  } chanCfg_t;

  function automatic int ctrlPos(int ch);
    return (ch == 0) ? 0 : 8 + GRP_BITS * (ch - 1);
  endfunction

  function automatic int grpOf(int ch);
    return (ch < 2) ? 0 : 1;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrlMask();
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      m[ctrlPos(c)]     = 1'b1;
      m[ctrlPos(c) + 1] = 1'b1;
      if (c < NUM_PWM) m[ctrlPos(c) + 2] = 1'b1;
      m[ctrlPos(c) + 3] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pwmt_chan.sv
module pwmt_chan
  import pwmt_pkg::*;
#(
  parameter bit HAS_CMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chanCfg_t         cfg,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             pwm
);
  logic [CNT_W-1:0] cntQ;
  logic             atZero;
  logic             stepNow;

  assign atZero  = (cntQ == '0);
  assign stepNow = cfg.run & tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ <= '0;
    end else if (cfg.load) begin
      cntQ <= cfg.cntBuf;
    end else if (stepNow) begin
      if (!atZero)          cntQ <= cntQ - 1'b1;
      else if (cfg.repeatOn) cntQ <= cfg.cntBuf;
    end
  end

  assign cnt = cntQ;

  generate
    if (HAS_CMP) begin : g_cmp
      logic [CNT_W-1:0] cmpQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cmpQ <= '0;
        end else if (cfg.load) begin
          cmpQ <= cfg.cmpBuf;
        end else if (stepNow && atZero && cfg.repeatOn) begin
          cmpQ <= cfg.cmpBuf;
        end
      end
      assign pwm = cfg.run ? ((cntQ <= cmpQ) ^ cfg.invert) : cfg.invert;
    end else begin : g_nocmp
      assign pwm = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pwmt_datapath.sv
module pwmt_datapath
  import pwmt_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  chanCfg_t [NUM_CH-1:0]             chanCfg,
  input  logic     [NUM_GRP-1:0][PRE_W-1:0] preVal,
  output logic     [NUM_CH-1:0][CNT_W-1:0]  obsCnt,
  output logic     [NUM_PWM-1:0]            pwmOut
);
  logic [NUM_GRP-1:0]               preTick;
  logic [NUM_GRP-1:0][DIVCNT_W-1:0] divCnt;
  logic [NUM_CH-1:0]                chPwm;

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic [PRE_W-1:0]    preCntQ;
      logic [DIVCNT_W-1:0] divCntQ;
      logic                hit;

      assign hit = (preCntQ >= preVal[g]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          preCntQ <= '0;
          divCntQ <= '0;
        end else if (hit) begin
          preCntQ <= '0;
          divCntQ <= divCntQ + 1'b1;
        end else begin
          preCntQ <= preCntQ + 1'b1;
        end
      end

      assign preTick[g] = hit;
      assign divCnt[g]  = divCntQ;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int GRP = grpOf(c);
      logic [DIVCNT_W-1:0] mask;
      logic                tick;
      logic [CNT_W-1:0]    cntW;
      logic                pwmW;

      assign mask = DIVCNT_W'((32'd1 << chanCfg[c].divSel) - 32'd1);
      assign tick = preTick[GRP] & (&(divCnt[GRP] | ~mask));

      pwmt_chan #(.HAS_CMP(c < NUM_PWM)) u_chan (
        .clk  (clk),
        .rst_n(rst_n),
        .cfg  (chanCfg[c]),
        .tick (tick),
        .cnt  (cntW),
        .pwm  (pwmW)
      );

      assign obsCnt[c] = cntW;
      assign chPwm[c]  = pwmW;
    end
  endgenerate

  assign pwmOut = chPwm[NUM_PWM-1:0];
endmodule

// File: rtl/pwmt_ctrl.sv
module pwmt_ctrl
  import pwmt_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic     [ADDR_W-1:0]             busAddr,
  input  logic     [DATA_W-1:0]             busWdata,
  input  logic                              busWe,
  output logic     [DATA_W-1:0]             busRdata,
  input  logic     [NUM_CH-1:0][CNT_W-1:0]  obsCnt,
  output chanCfg_t [NUM_CH-1:0]             chanCfg,
  output logic     [NUM_GRP-1:0][PRE_W-1:0] preVal
);
  localparam int PRE_REG_W = NUM_GRP * PRE_W;
  localparam int DIV_REG_W = NUM_CH * DIV_W;
  localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);
  localparam logic [CTRL_W-1:0] CTRL_MASK = ctrlMask();

  logic [PRE_REG_W-1:0]              preReg;
  logic [DIV_REG_W-1:0]              divReg;
  logic [CTRL_W-1:0]                 ctrlReg;
  logic [NUM_CH-1:0][CNT_W-1:0]      cntBufReg;
  logic [NUM_PWM-1:0][CNT_W-1:0]     cmpBufReg;

  function automatic logic [ADDR_W-1:0] chAddr(int ch, int slot);
    return ADDR_W'(REG_BASE + REG_STEP * ch + slot);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preReg    <= '0;
      divReg    <= '0;
      ctrlReg   <= '0;
      cntBufReg <= '0;
      cmpBufReg <= '0;
    end else if (busWe) begin
      if (busAddr == A_PRE)  preReg  <= busWdata[PRE_REG_W-1:0];
      if (busAddr == A_DIV)  divReg  <= busWdata[DIV_REG_W-1:0];
      if (busAddr == A_CTRL) ctrlReg <= busWdata[CTRL_W-1:0] & CTRL_MASK;
      for (int c = 0; c < NUM_CH; c++) begin
        if (busAddr == chAddr(c, 0)) cntBufReg[c] <= busWdata[CNT_W-1:0];
      end
      for (int c = 0; c < NUM_PWM; c++) begin
        if (busAddr == chAddr(c, 1)) cmpBufReg[c] <= busWdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == A_PRE)  busRdata = DATA_W'(preReg);
    if (busAddr == A_DIV)  busRdata = DATA_W'(divReg);
    if (busAddr == A_CTRL) busRdata = DATA_W'(ctrlReg);
    for (int c = 0; c < NUM_CH; c++) begin
      if (busAddr == chAddr(c, 0)) busRdata = DATA_W'(cntBufReg[c]);
      if (busAddr == chAddr(c, 2)) busRdata = DATA_W'(obsCnt[c]);
    end
    for (int c = 0; c < NUM_PWM; c++) begin
      if (busAddr == chAddr(c, 1)) busRdata = DATA_W'(cmpBufReg[c]);
    end
  end

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
      assign preVal[g] = preReg[g*PRE_W +: PRE_W];
    end
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cfg
      localparam int POS = ctrlPos(c);
      assign chanCfg[c].run      = ctrlReg[POS];
      assign chanCfg[c].load     = ctrlReg[POS+1];
      assign chanCfg[c].invert   = ctrlReg[POS+2];
      assign chanCfg[c].repeatOn = ctrlReg[POS+3];
      assign chanCfg[c].divSel   = divReg[c*DIV_W +: DIV_W];
      assign chanCfg[c].cntBuf   = cntBufReg[c];
      if (c < NUM_PWM) begin : g_hasCmp
        assign chanCfg[c].cmpBuf = cmpBufReg[c];
      end else begin : g_noCmp
        assign chanCfg[c].cmpBuf = '0;
      end
    end
  endgenerate
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               busWe,
  output logic [DATA_W-1:0]  busRdata,
  output logic [NUM_PWM-1:0] pwmOut
);
  chanCfg_t [NUM_CH-1:0]             chanCfg;
  logic     [NUM_GRP-1:0][PRE_W-1:0] preVal;
  logic     [NUM_CH-1:0][CNT_W-1:0]  obsCnt;

  pwmt_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .busAddr (busAddr),
    .busWdata(busWdata),
    .busWe   (busWe),
    .busRdata(busRdata),
    .obsCnt  (obsCnt),
    .chanCfg (chanCfg),
    .preVal  (preVal)
  );

  pwmt_datapath u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .chanCfg(chanCfg),
    .preVal (preVal),
    .obsCnt (obsCnt),
    .pwmOut (pwmOut)
  );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
  import pwmt_pkg::*;
(
  input logic                             clk,
  input logic                             rst_n,
  input chanCfg_t [NUM_CH-1:0]            chanCfg,
  input logic     [NUM_CH-1:0][CNT_W-1:0] obsCnt,
  input logic     [NUM_PWM-1:0]           pwmOut
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      // R4: a held load bit copies the reload buffer on the next edge
      a_r4_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        chanCfg[c].load |=> obsCnt[c] == $past(chanCfg[c].cntBuf));

      // R8: a halted channel keeps its count
      a_r8_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!chanCfg[c].run && !chanCfg[c].load) |=> $stable(obsCnt[c]));

      // R6: no repeat means zero is final
      a_r6_stay_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (chanCfg[c].run && !chanCfg[c].load && !chanCfg[c].repeatOn && obsCnt[c] == '0)
        |=> obsCnt[c] == '0);

      // R5: a nonzero running count holds or drops by exactly one
      a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (chanCfg[c].run && !chanCfg[c].load && obsCnt[c] != '0)
        |=> (obsCnt[c] == $past(obsCnt[c]) ||
             obsCnt[c] == CNT_W'($past(obsCnt[c]) - 1'b1)));
    end
    for (genvar c = 0; c < NUM_PWM; c++) begin : g_out
      // R8: halted output sits at the inverter level
      a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !chanCfg[c].run |-> pwmOut[c] == chanCfg[c].invert);
    end
  endgenerate
endmodule

bind pwm_timer pwm_timer_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .chanCfg(chanCfg),
  .obsCnt (obsCnt),
  .pwmOut (pwmOut)
);

// File: tb/pwm_timer_bench.sv
module pwm_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic [31:0] busRdata;
  logic [3:0]  pwmOut;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  pwm_timer u_pwm_timer (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .pwmOut(pwmOut)
  );

  always #10 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int mPresc, mDiv, mCtrl;
  int mCntBuf[5], mCmpBuf[5], mCnt[5], mCmp[5];
  int mPreCnt[2], mDivCnt[2];

  function automatic int bitBase(int c);
    return (c == 0) ? 0 : 8 + 4 * (c - 1);
  endfunction
  function automatic int fld(int c, int k);
    return (mCtrl >> (bitBase(c) + k)) & 1;
  endfunction

  task automatic modelReset();
    mPresc = 0; mDiv = 0; mCtrl = 0;
    for (int c = 0; c < 5; c++) begin
      mCntBuf[c] = 0; mCmpBuf[c] = 0; mCnt[c] = 0; mCmp[c] = 0;
    end
    for (int g = 0; g < 2; g++) begin mPreCnt[g] = 0; mDivCnt[g] = 0; end
  endtask

  task automatic modelStep();
    bit pt[2];
    bit ct[5];
    for (int g = 0; g < 2; g++) pt[g] = (mPreCnt[g] >= ((mPresc >> (8 * g)) & 255));
    for (int c = 0; c < 5; c++) begin
      int g = (c < 2) ? 0 : 1;
      int per = 1 << ((mDiv >> (4 * c)) & 15);
      ct[c] = pt[g] && ((mDivCnt[g] % per) == per - 1);
    end
    for (int c = 0; c < 5; c++) begin
      if (fld(c, 1) == 1) begin
        mCnt[c] = mCntBuf[c]; mCmp[c] = mCmpBuf[c];
      end else if (fld(c, 0) == 1 && ct[c]) begin
        if (mCnt[c] != 0) mCnt[c] = mCnt[c] - 1;
        else if (fld(c, 3) == 1) begin mCnt[c] = mCntBuf[c]; mCmp[c] = mCmpBuf[c]; end
      end
    end
    for (int g = 0; g < 2; g++) begin
      if (pt[g]) begin mPreCnt[g] = 0; mDivCnt[g] = (mDivCnt[g] + 1) % 32768; end
      else mPreCnt[g] = mPreCnt[g] + 1;
    end
    if (busWe) begin
      int a = int'(busAddr);
      if (a == 0) mPresc = busWdata & 32'hFFFF;
      if (a == 1) mDiv = busWdata & 32'hF_FFFF;
      if (a == 2) mCtrl = busWdata & 32'hBF_FF0F;
      for (int c = 0; c < 5; c++) begin
        if (a == 3 + 3 * c) mCntBuf[c] = busWdata & 32'hFFFF;
        if (c < 4 && a == 4 + 3 * c) mCmpBuf[c] = busWdata & 32'hFFFF;
      end
    end
  endtask

  function automatic int modelRead(int a);
    if (a == 0) return mPresc;
    if (a == 1) return mDiv;
    if (a == 2) return mCtrl;
    for (int c = 0; c < 5; c++) begin
      if (a == 3 + 3 * c) return mCntBuf[c];
      if (a == 4 + 3 * c) return (c < 4) ? mCmpBuf[c] : 0;
      if (a == 5 + 3 * c) return mCnt[c];
    end
    return 0;
  endfunction

  function automatic bit modelPwm(int c);
    bit inv = fld(c, 2) == 1;
    if (fld(c, 0) == 0) return inv;
    return (mCnt[c] <= mCmp[c]) ^ inv;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) modelReset();
    else modelStep();
  end

  // ---------------- check helpers ----------------
  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compareModel();
    for (int c = 0; c < 4; c++) check("R7 output vs model", int'(pwmOut[c]), int'(modelPwm(c)));
    check("R2 read data vs model", int'(busRdata), modelRead(int'(busAddr)));
  endtask

  task automatic stepCycle();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) compareModel();
  endtask

  task automatic busWrite(int a, int d);
    busAddr = 5'(a); busWdata = 32'(d); busWe = 1'b1;
    stepCycle();
    busWe = 1'b0;
  endtask

  task automatic busRead(int a, output int d);
    busAddr = 5'(a);
    #1 d = int'(busRdata);
  endtask

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) stepCycle();
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  // ---------------- directed sequence ----------------
  initial begin
    int d, d2, highs, lo, hi, prev, nChg, chg1, chg2, chg3, zeroSeen;
    bit ok;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 18; a++) begin
      busRead(a, d);
      check("R1 register reset value", d, 0);
    end
    check("R1 outputs after reset", int'(pwmOut), 0);

    // R2 and R9: register widths, masks, write-ignored slots
    busWrite(0, 32'h1234_5678);
    busRead(0, d); check("R2 prescaler word width", d, 32'h5678);
    busWrite(1, 32'hFFFF_FFFF);
    busRead(1, d); check("R2 divider word width", d, 32'hF_FFFF);
    busWrite(2, 32'hFFFF_FFFF);
    busRead(2, d); check("R9 control mask, bit 22 absent", d, 32'hBF_FF0F);
    busWrite(2, 0);
    busWrite(16, 32'hFFFF);
    busRead(16, d); check("R2 channel 4 compare slot ignored", d, 0);
    busWrite(5, 32'h55);
    busRead(5, d); check("R2 live count read-only", d, 0);
    busWrite(0, 0);
    busWrite(1, 0);

    // R5 and R7: channel 0, reload 4, compare 2, tick every clock
    busWrite(3, 4);
    busWrite(4, 2);
    busWrite(2, 32'h2);
    busWrite(2, 32'h9);
    waitCycles(3);
    highs = 0;
    for (int i = 0; i < 10; i++) begin highs += int'(pwmOut[0]); stepCycle(); end
    check("R7 active cycles per two periods", highs, 6);
    busRead(5, prev);
    zeroSeen = 0; ok = 1'b1;
    for (int i = 0; i < 12; i++) begin
      stepCycle();
      busRead(5, d);
      if (prev == 0) begin zeroSeen++; if (d != 4) ok = 1'b0; end
      else if (d != prev - 1) ok = 1'b0;
      prev = d;
    end
    check("R5 decrement and reload from zero", int'(ok), 1);
    check("R5 zero reached", int'(zeroSeen >= 2), 1);
    busWrite(2, 32'hD);
    waitCycles(2);
    highs = 0;
    for (int i = 0; i < 10; i++) begin highs += int'(pwmOut[0]); stepCycle(); end
    check("R7 inverted active cycles", highs, 4);
    busWrite(3, 6);          // buffer change while counting
    waitCycles(9);

    // R8: halt with invert set
    busWrite(2, 32'hC);
    waitCycles(2);
    check("R8 halted output at invert level", int'(pwmOut[0]), 1);
    busRead(5, d);
    waitCycles(10);
    busRead(5, d2);
    check("R8 halted count frozen", d2, d);

    // R3: channel 2, prescaler 2, divide by 2 -> one step per 6 clocks
    busWrite(0, 32'h200);
    busWrite(1, 32'h100);
    busWrite(9, 1000);
    busWrite(10, 0);
    busWrite(2, 32'h2000);
    busWrite(2, 32'h9000);
    busRead(11, prev);
    nChg = 0; chg1 = 0; chg2 = 0; chg3 = 0; ok = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      stepCycle();
      busRead(11, d);
      if (d != prev) begin
        nChg++;
        if (d != prev - 1) ok = 1'b0;
        if (nChg == 1) chg1 = i;
        if (nChg == 2) chg2 = i;
        if (nChg == 3) chg3 = i;
      end
      prev = d;
    end
    check("R3 step spacing first pair", chg2 - chg1, 6);
    check("R3 step spacing second pair", chg3 - chg2, 6);
    check("R3 steps are single decrements", int'(ok), 1);

    // R6: channel 1 runs once without repeat
    busWrite(6, 3);
    busWrite(7, 1);
    busWrite(2, 32'h200);
    busWrite(2, 32'h100);
    waitCycles(20);
    busRead(8, d);
    check("R6 count rests at zero", d, 0);
    check("R6 output active at zero", int'(pwmOut[1]), 1);
    waitCycles(10);
    busRead(8, d);
    check("R6 count still zero", d, 0);

    // R4: channel 3 with load and run held together
    busWrite(12, 50);
    busWrite(2, 32'h3_0000);
    waitCycles(3);
    busRead(14, d);
    check("R4 load holds count at buffer", d, 50);
    waitCycles(10);
    busRead(14, d);
    check("R4 load beats ticks", d, 50);

    // R10: channel 4 countdown, prescaler group 1 at 2
    busWrite(1, 0);
    busWrite(15, 2);
    busWrite(2, 32'h20_0000);
    busWrite(2, 32'h90_0000);
    lo = 99; hi = -1; ok = 1'b1;
    busRead(17, prev);
    for (int i = 0; i < 30; i++) begin
      stepCycle();
      busRead(17, d);
      if (d < lo) lo = d;
      if (d > hi) hi = d;
      if (prev == 0 && d != 0 && d != 2) ok = 1'b0;
      prev = d;
    end
    check("R10 timer minimum", lo, 0);
    check("R10 timer maximum", hi, 2);
    check("R10 timer reload value", int'(ok), 1);
    check("R10 no output from timer", int'(pwmOut), 0);

    waitCycles(5);
    finishRun();
  end
endmodule